// File: doc/BRIEF.md
# Dual Retriggerable One-Shot Pulse Generator

This block produces clean, fixed-length pulses from asynchronous trigger inputs. The pulse width is set as a clock-cycle count instead of an external resistor and capacitor. It contains a configurable number of identical channels, two by default. Each channel has a rising-edge trigger and a falling-edge trigger, its own active-low clear, a mode bit that selects whether a pulse can be extended, its own period value, and a true output with a complementary output.

Each trigger input passes through a two-flop synchronizer before its edge is detected, so the start latency is a fixed three clock cycles whatever the period. The clear acts asynchronously on the pulse counter, so the output drops without waiting for a clock edge. In extendable mode every accepted trigger reloads the full period. In single-shot mode, triggers that arrive during a pulse are dropped.

Top module: `dual_oneshot`

## Requirements
- R1: A low-to-high transition on `trig_pos_i[c]` makes `q_o[c]` high from the third rising clock edge after the input changes, for every period setting.
- R2: A high-to-low transition on `trig_neg_i[c]` starts a pulse with the same three-edge latency. The opposite transitions on either input start nothing.
- R3: A single trigger gives a pulse that is high for exactly P clock cycles, where P is the channel's slice `period_i[c*CW +: CW]`.
- R4: When `retrig_i[c]` is 1, a trigger that arrives during a pulse reloads the count, so the pulse ends P cycles after that latest trigger is accepted.
- R5: When `retrig_i[c]` is 0, triggers that arrive during a pulse are ignored, so the pulse lasts exactly P cycles.
- R6: While `clr_ni[c]` is low, `q_o[c]` is low with no clock edge needed, and no trigger can start a pulse.
- R7: The rising edge of `clr_ni[c]` does not start a pulse, even if a trigger input changed while clear was low.
- R8: `qn_o[c]` is always the inverse of `q_o[c]`, including during reset.
- R9: A period value of 0 acts as a period of 1 cycle.
- R10: Edges on both trigger inputs in the same cycle count as one trigger.
- R11: Channels are independent. Activity on one channel never changes the outputs of another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Global asynchronous reset, active low |
| clr_ni | input | NCH | Per-channel asynchronous pulse clear, active low |
| trig_pos_i | input | NCH | Rising-edge trigger inputs, asynchronous |
| trig_neg_i | input | NCH | Falling-edge trigger inputs, asynchronous |
| retrig_i | input | NCH | 1 = extendable mode, 0 = single-shot mode |
| period_i | input | NCH*CW | Pulse period in cycles, CW bits per channel, channel c in bits c*CW +: CW |
| q_o | output | NCH | Pulse outputs |
| qn_o | output | NCH | Complementary pulse outputs |

## Verification
The assertions check on every cycle the properties that hold at any moment:
- The two outputs of a channel are complementary.
- A cleared channel is low.
- Every output rise traces back to a qualifying trigger edge exactly three samples earlier.
- In single-shot mode no high run exceeds the period.

Only the bench scenarios show the rest:
- The exact pulse widths.
- Extension by a later trigger.
- That the release of clear starts nothing.
- That coincident edges merge into one trigger.
- That the channels are isolated.

The bench sweeps every period value of a narrow counter in both modes, both polarities and both channels.

// File: rtl/oneshot_pkg.sv
package oneshot_pkg;
  localparam int unsigned SYNC_DEPTH = 2;

  typedef enum logic {
    MODE_SINGLE = 1'b0,
    MODE_EXTEND = 1'b1
  } os_mode_e;
endpackage

// File: rtl/os_sync.sv
module os_sync #(
  parameter int unsigned W = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  localparam int unsigned D = oneshot_pkg::SYNC_DEPTH;

  logic [W-1:0] stg [D];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < D; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d_i;
      for (int i = 1; i < D; i++) stg[i] <= stg[i-1];
    end
  end

  assign q_o = stg[D-1];
endmodule

// File: rtl/os_edge.sv
module os_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pos_i,
  input  logic neg_i,
  output logic fire_o
);
  logic pos_q, neg_q;

  // reset to idle levels so that a quiet input never looks like an edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q <= 1'b0;
      neg_q <= 1'b1;
    end else begin
      pos_q <= pos_i;
      neg_q <= neg_i;
    end
  end

  // coincident edges merge into one trigger
  assign fire_o = (pos_i & ~pos_q) | (~neg_i & neg_q);
endmodule

// File: rtl/os_timer.sv
module os_timer #(
  parameter int unsigned CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fire_i,
  input  oneshot_pkg::os_mode_e mode_i,
  input  logic [CW-1:0] period_i,
  output logic          active_o
);
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] per_eff;
  logic          load;

  assign per_eff  = (period_i == '0) ? CW'(1) : period_i;
  assign active_o = |cnt_q;
  assign load     = fire_i & ((mode_i == oneshot_pkg::MODE_EXTEND) | ~active_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (load)      cnt_q <= per_eff;
    else if (active_o)  cnt_q <= cnt_q - CW'(1);
  end
endmodule

// File: rtl/os_channel.sv
module os_channel #(
  parameter int unsigned CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_ni,
  input  logic          pos_i,
  input  logic          neg_i,
  input  logic          retrig_i,
  input  logic [CW-1:0] period_i,
  output logic          q_o,
  output logic          qn_o
);
  logic [1:0] trig_s;
  logic       fire;
  logic       active;
  logic       kill_n;
  oneshot_pkg::os_mode_e mode;

  // the synchronizer and edge flops see only the global reset, so a clear release finds no stale edge
  os_sync #(.W(2), .RST_VAL(2'b10)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({neg_i, pos_i}),
    .q_o   (trig_s)
  );

  os_edge u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .pos_i (trig_s[0]),
    .neg_i (trig_s[1]),
    .fire_o(fire)
  );

  assign kill_n = rst_ni & clr_ni;
  assign mode   = oneshot_pkg::os_mode_e'(retrig_i);

  os_timer #(.CW(CW)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (kill_n),
    .fire_i  (fire),
    .mode_i  (mode),
    .period_i(period_i),
    .active_o(active)
  );

  assign q_o  = active;
  assign qn_o = ~active;
endmodule

// File: rtl/dual_oneshot.sv
module dual_oneshot #(
  parameter int unsigned NCH = 2,
  parameter int unsigned CW  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NCH-1:0]    clr_ni,
  input  logic [NCH-1:0]    trig_pos_i,
  input  logic [NCH-1:0]    trig_neg_i,
  input  logic [NCH-1:0]    retrig_i,
  input  logic [NCH*CW-1:0] period_i,
  output logic [NCH-1:0]    q_o,
  output logic [NCH-1:0]    qn_o
);
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    os_channel #(.CW(CW)) u_ch (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clr_ni  (clr_ni[c]),
      .pos_i   (trig_pos_i[c]),
      .neg_i   (trig_neg_i[c]),
      .retrig_i(retrig_i[c]),
      .period_i(period_i[c*CW +: CW]),
      .q_o     (q_o[c]),
      .qn_o    (qn_o[c])
    );
  end
endmodule

// File: rtl/dual_oneshot_sva.sv
module dual_oneshot_sva #(
  parameter int unsigned NCH = 2,
  parameter int unsigned CW  = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [NCH-1:0]    clr_ni,
  input logic [NCH-1:0]    trig_pos_i,
  input logic [NCH-1:0]    trig_neg_i,
  input logic [NCH-1:0]    retrig_i,
  input logic [NCH*CW-1:0] period_i,
  input logic [NCH-1:0]    q_o,
  input logic [NCH-1:0]    qn_o
);
  for (genvar c = 0; c < NCH; c++) begin : g_chk
    logic [CW:0] run_q;
    logic [CW:0] eff;

    assign eff = (period_i[c*CW +: CW] == '0) ? (CW+1)'(1) : {1'b0, period_i[c*CW +: CW]};

    // consecutive high samples before the current one
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)             run_q <= '0;
      else if (!q_o[c])        run_q <= '0;
      else if (run_q != '1)    run_q <= run_q + 1'b1;
    end

    a_r8_complement: assert property (@(posedge clk_i) qn_o[c] == ~q_o[c]);

    a_r6_clear_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !clr_ni[c] |-> !q_o[c]);

    a_r1_r2_start_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(q_o[c]) |->
        (($past(trig_pos_i[c], 3) && !$past(trig_pos_i[c], 4)) ||
         (!$past(trig_neg_i[c], 3) && $past(trig_neg_i[c], 4))));

    a_r5_single_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (q_o[c] && !retrig_i[c]) |-> (run_q < eff));
  end
endmodule

bind dual_oneshot dual_oneshot_sva #(.NCH(NCH), .CW(CW)) u_sva (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .clr_ni    (clr_ni),
  .trig_pos_i(trig_pos_i),
  .trig_neg_i(trig_neg_i),
  .retrig_i  (retrig_i),
  .period_i  (period_i),
  .q_o       (q_o),
  .qn_o      (qn_o)
);

// File: tb/dual_oneshot_tb.sv
`timescale 1ns/1ps
module dual_oneshot_tb;
  localparam int NCH = 2;
  localparam int CW  = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NCH-1:0]    clr_n = '1;
  logic [NCH-1:0]    tpos = '0;
  logic [NCH-1:0]    tneg = '1;
  logic [NCH-1:0]    retrig = '0;
  logic [NCH*CW-1:0] period = '0;
  logic [NCH-1:0]    q, qn;

  int vectors = 0;
  int fails   = 0;

  always #2.5 clk = ~clk;

  dual_oneshot #(.NCH(NCH), .CW(CW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .clr_ni(clr_n), .trig_pos_i(tpos),
    .trig_neg_i(tneg), .retrig_i(retrig), .period_i(period),
    .q_o(q), .qn_o(qn)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // kind: 0 rising on pos, 1 falling on neg, 2 both together
  task automatic drive_edge(input int ch, input int kind);
    if (kind != 1) tpos[ch] = 1'b1;
    if (kind != 0) tneg[ch] = 1'b0;
  endtask

  task automatic idle(input int ch);
    tpos[ch] = 1'b0;
    tneg[ch] = 1'b1;
  endtask

  task automatic burst(input int ch, input int kind, input int sep,
                       output int highs, output int first, output int other, output int qbad);
    highs = 0; first = -1; other = 0; qbad = 0;
    for (int k = 0; k < 32; k++) begin
      @(negedge clk);
      if (q[ch]) begin
        highs++;
        if (first < 0) first = k;
      end
      if (qn[ch] != ~q[ch]) qbad++;
      if (q[1-ch]) other++;
      if (k == 0 || (sep > 0 && k == sep)) drive_edge(ch, kind);
      if (k == 1 || (sep > 0 && k == sep + 1)) idle(ch);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    int h, f, o, b;
    #1;
    chk(q == '0, "R6 reset q", int'(q), 0);
    chk(qn == '1, "R8 reset qn", int'(qn), 3);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // sweep: channel, mode, polarity, every period value
    for (int ch = 0; ch < NCH; ch++)
      for (int m = 0; m < 2; m++)
        for (int kind = 0; kind < 2; kind++)
          for (int p = 0; p < (1 << CW); p++) begin
            int exp_w;
            exp_w = (p == 0) ? 1 : p;
            retrig[ch] = m[0];
            period[ch*CW +: CW] = CW'(p);
            burst(ch, kind, 0, h, f, o, b);
            chk(f == 3, kind ? "R2 latency" : "R1 latency", f, 3);
            chk(h == exp_w, (p == 0) ? "R9 zero period" : "R3 width", h, exp_w);
            chk(o == 0, "R11 other channel", o, 0);
            chk(b == 0, "R8 complement", b, 0);
          end

    // R4 extension
    retrig = '1;
    period[0 +: CW] = 4'd6;
    burst(0, 0, 4, h, f, o, b);
    chk(h == 10, "R4 extend pos", h, 10);
    burst(0, 1, 3, h, f, o, b);
    chk(h == 9, "R4 extend neg", h, 9);
    period[CW +: CW] = 4'd9;
    burst(1, 0, 5, h, f, o, b);
    chk(h == 14, "R4 extend ch1", h, 14);
    chk(o == 0, "R11 ch0 quiet", o, 0);

    // R5 single-shot ignores triggers mid-pulse
    retrig = '0;
    burst(0, 0, 4, h, f, o, b);
    chk(h == 6, "R5 ignore pos", h, 6);
    burst(0, 1, 2, h, f, o, b);
    chk(h == 6, "R5 ignore neg", h, 6);

    // R10 coincident edges
    period[0 +: CW] = 4'd5;
    burst(0, 2, 0, h, f, o, b);
    chk(h == 5 && f == 3, "R10 both single", h, 5);
    retrig[0] = 1'b1;
    burst(0, 2, 0, h, f, o, b);
    chk(h == 5, "R10 both extend", h, 5);

    // R6 clear kills the pulse and blocks triggers
    period[0 +: CW] = 4'd10;
    h = 0;
    for (int k = 0; k < 32; k++) begin
      @(negedge clk);
      if (q[0]) h++;
      if (k == 0) tpos[0] = 1'b1;
      if (k == 1) tpos[0] = 1'b0;
      if (k == 5) begin
        clr_n[0] = 1'b0;
        #1;
        chk(q[0] == 1'b0 && qn[0] == 1'b1, "R6 async kill", int'(q[0]), 0);
      end
      if (k == 7) tpos[0] = 1'b1;
      if (k == 8) tpos[0] = 1'b0;
      if (k == 12) clr_n[0] = 1'b1;
    end
    chk(h == 3, "R6 blocked trigger", h, 3);

    // R7 clear release with a changed trigger level
    h = 0;
    for (int k = 0; k < 32; k++) begin
      @(negedge clk);
      if (q[0]) h++;
      if (k == 0) clr_n[0] = 1'b0;
      if (k == 2) tpos[0] = 1'b1;
      if (k == 8) clr_n[0] = 1'b1;
      if (k == 20) tpos[0] = 1'b0;
    end
    chk(h == 0, "R7 no pulse on release", h, 0);
    burst(0, 0, 0, h, f, o, b);
    chk(h == 10, "R7 normal after release", h, 10);

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule